// File: doc/BRIEF.md
# Multi-core interrupt distributor with acknowledge

This block collects interrupt requests for a small multi-core cluster and presents each core with a single IRQ line. Requests arrive from three classes. Software-triggered inter-core interrupts (IDs 0..15) are raised by a register write that names the target cores. Per-core private peripheral interrupts (IDs 16..31) are kept as a separate copy for every core. Shared peripheral interrupts (IDs 32 and up, `NUM_SHARED` of them) may be serviced by any core chosen through a per-interrupt target bitmap. A rising edge on a request line is latched as pending, so a one-cycle pulse is never lost.

For each core, an arbiter scans the eligible interrupts. An interrupt is eligible when it is pending and not active, its own enable and the global enable are both set, and it is routed to that core. The lowest priority value wins, and among equal values the lower ID wins. A core's acknowledge read returns the winning ID and moves that interrupt from pending to active. A later end-of-interrupt write carrying the ID retires it. All access goes through a plain single-cycle register port with a core-select input. Read data is combinational in the cycle of the read, and any state change lands on the following clock edge. The port has no back-pressure, because every access completes in its own cycle.

Top module: `mc_irq_dist`

## Requirements
- R1: After reset, every IRQ output is low, the control word and every configuration word read as zero, and an acknowledge read returns 1023.
- R2: A core's IRQ is asserted only while the global enable (control word, address 0x000, bit 0) is 1 and the interrupt's own enable bit is 1; clearing either one drops the IRQ without losing the pending state.
- R3: A rising edge on a peripheral line sets pending, and pending stays set after the line falls; a line held high after acknowledge does not set pending again.
- R4: An acknowledge read (address 0x002, by the core on `reg_core`) returns the ID of the eligible interrupt with the lowest priority value and in the next cycle shows it active and not pending.
- R5: Among eligible interrupts with equal priority values, the lower ID is returned first.
- R6: An acknowledge read with nothing eligible for that core returns 1023 and changes no pending or active state.
- R7: An end-of-interrupt write (address 0x003, ID in data bits [9:0]) clears the active state of that ID only; an ID that is out of range or not active has no effect.
- R8: An active interrupt does not assert IRQ; a new edge that arrives while it is active is recorded as pending and asserts IRQ once the end-of-interrupt write retires it.
- R9: A write to address 0x001 with the ID in bits [3:0] and a core bitmap in bits [16+c] makes that software interrupt pending for each selected core only.
- R10: IDs 16..31 are banked per core: line `ppi_lines[16*c + (id-16)]` and configuration accesses with `reg_core`=c affect only core c's copy.
- R11: A shared interrupt asserts IRQ on every core whose bit is set in its target field, and once one core acknowledges it, it is no longer eligible for any core.
- R12: The configuration word for ID n is at address 0x100+n: bit 0 enable, bits [8 +: PRIO_W] priority, bits [16 +: NUM_CORES] target (stored for shared IDs, reads 0 for IDs below 32), bit 30 pending and bit 31 active (read only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ppi_lines | input | 16*NUM_CORES | Private peripheral request lines, 16 per core |
| spi_lines | input | NUM_SHARED | Shared peripheral request lines, bit i is ID 32+i |
| reg_core | input | CORE_W | Core issuing the current register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 9 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| irq | output | NUM_CORES | Per-core interrupt request |

## Verification
The bench targets ordering and lifecycle corners. These include equal priorities, where a wrong tie-break hands out ID 50 before 45. An acknowledge with a pending but disabled interrupt must leave it pending; a faulty design would swallow it or return its ID. A fresh edge while an interrupt is active must stay hidden until end-of-interrupt; a faulty design raises IRQ early or drops the second edge. A shared interrupt acknowledged by one core must vanish from the other, because a race-prone design would deliver it twice. Banking checks confirm that a private line or software trigger for one core never raises the other core's IRQ, and that end-of-interrupt writes with foreign or out-of-range IDs leave the active state intact.

// File: rtl/mc_irq_pkg.sv
package mc_irq_pkg;

  localparam int ADDR_W   = 9;
  localparam int N_SWI    = 16;   // software-triggered IDs 0..15
  localparam int N_PRIV   = 16;   // private IDs 16..31
  localparam int N_LOCAL  = N_SWI + N_PRIV;
  localparam int EOI_ID_W = 10;

  localparam logic [EOI_ID_W-1:0] SPURIOUS_ID = 10'd1023;

  localparam logic [ADDR_W-1:0] ADR_CTRL     = 9'h000;
  localparam logic [ADDR_W-1:0] ADR_SWI      = 9'h001;
  localparam logic [ADDR_W-1:0] ADR_ACK      = 9'h002;
  localparam logic [ADDR_W-1:0] ADR_EOI      = 9'h003;
  localparam logic [ADDR_W-1:0] ADR_CFG_BASE = 9'h100;

  // configuration word field positions
  localparam int CF_EN   = 0;
  localparam int CF_PRIO = 8;
  localparam int CF_TGT  = 16;
  localparam int CF_PEND = 30;
  localparam int CF_ACT  = 31;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CTRL,
    ACC_SWI,
    ACC_ACK,
    ACC_EOI,
    ACC_CFG
  } acc_kind_e;

endpackage

// File: rtl/mc_irq_bank.sv
// Pending / active / enable / priority / target state for a group of IDs.
module mc_irq_bank #(
  parameter int N      = 32,
  parameter int PRIO_W = 4,
  parameter int TGT_W  = 2,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        line_in,
  input  logic [N-1:0]        sw_set,
  input  logic                cfg_we,
  input  logic [IW-1:0]       cfg_idx,
  input  logic                cfg_en,
  input  logic [PRIO_W-1:0]   cfg_prio,
  input  logic [TGT_W-1:0]    cfg_tgt,
  input  logic                ack_take,
  input  logic [IW-1:0]       ack_idx,
  input  logic                eoi_take,
  input  logic [IW-1:0]       eoi_idx,
  output logic [N-1:0]        pend_o,
  output logic [N-1:0]        act_o,
  output logic [N-1:0]        en_o,
  output logic [N*PRIO_W-1:0] prio_o,
  output logic [N*TGT_W-1:0]  tgt_o
);

  logic [N-1:0]        line_q;
  logic [N-1:0]        pend_q;
  logic [N-1:0]        act_q;
  logic [N-1:0]        en_q;
  logic [PRIO_W-1:0]   prio_q [N];
  logic [TGT_W-1:0]    tgt_q  [N];
  logic [N-1:0]        ack_mask;
  logic [N-1:0]        eoi_mask;
  logic [N-1:0]        rise;

  assign ack_mask = ack_take ? (N'(1) << ack_idx) : '0;
  assign eoi_mask = eoi_take ? (N'(1) << eoi_idx) : '0;
  assign rise     = line_in & ~line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
      act_q  <= '0;
      en_q   <= '0;
      for (int i = 0; i < N; i++) begin
        prio_q[i] <= '0;
        tgt_q[i]  <= '0;
      end
    end else begin
      line_q <= line_in;
      // a new request in the same cycle as the acknowledge survives
      pend_q <= (pend_q & ~ack_mask) | rise | sw_set;
      // acknowledge wins over a retire of the same ID
      act_q  <= (act_q & ~eoi_mask) | ack_mask;
      if (cfg_we) begin
        en_q[cfg_idx]   <= cfg_en;
        prio_q[cfg_idx] <= cfg_prio;
        tgt_q[cfg_idx]  <= cfg_tgt;
      end
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
  assign en_o   = en_q;

  for (genvar i = 0; i < N; i++) begin : g_flat
    assign prio_o[i*PRIO_W +: PRIO_W] = prio_q[i];
    assign tgt_o[i*TGT_W +: TGT_W]    = tgt_q[i];
  end

endmodule

// File: rtl/mc_irq_pick.sv
// Lowest priority value wins; equal values go to the lower index.
module mc_irq_pick #(
  parameter int N      = 64,
  parameter int PRIO_W = 4,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        elig,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                found,
  output logic [IW-1:0]       idx
);

  logic [PRIO_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the earlier (lower) index on a tie
      if (elig[i] && (!found || (prio[i*PRIO_W +: PRIO_W] < best))) begin
        found = 1'b1;
        best  = prio[i*PRIO_W +: PRIO_W];
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/mc_irq_dist.sv
module mc_irq_dist
  import mc_irq_pkg::*;
#(
  parameter int NUM_CORES  = 2,
  parameter int NUM_SHARED = 32,
  parameter int PRIO_W     = 4,
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [16*NUM_CORES-1:0] ppi_lines,
  input  logic [NUM_SHARED-1:0]   spi_lines,
  input  logic [CORE_W-1:0]       reg_core,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic [NUM_CORES-1:0]    irq
);

  localparam int N_IDS = N_LOCAL + NUM_SHARED;
  localparam int IDX_W = $clog2(N_IDS);
  localparam int SH_W  = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;
  localparam int LW    = $clog2(N_LOCAL);

  // ---------------- decode ----------------
  acc_kind_e            kind;
  logic [ADDR_W:0]      cfg_off;
  logic                 cfg_ok;
  logic [IDX_W-1:0]     cfg_id;
  logic                 cfg_local;
  logic                 wr_cfg;
  logic [EOI_ID_W-1:0]  eoi_id;
  logic                 eoi_wr;
  logic                 eoi_local;
  logic                 eoi_sh;
  logic [N_SWI-1:0]     swi_vec;
  logic                 glob_en;
  logic                 wdata_unused;

  assign cfg_off   = {1'b0, reg_addr} - {1'b0, ADR_CFG_BASE};
  assign cfg_ok    = (reg_addr >= ADR_CFG_BASE) && (cfg_off < (ADDR_W+1)'(N_IDS));
  assign cfg_id    = cfg_off[IDX_W-1:0];
  assign cfg_local = cfg_id < IDX_W'(N_LOCAL);

  always_comb begin
    if (reg_addr == ADR_CTRL)     kind = ACC_CTRL;
    else if (reg_addr == ADR_SWI) kind = ACC_SWI;
    else if (reg_addr == ADR_ACK) kind = ACC_ACK;
    else if (reg_addr == ADR_EOI) kind = ACC_EOI;
    else if (cfg_ok)              kind = ACC_CFG;
    else                          kind = ACC_NONE;
  end

  assign wr_cfg    = reg_wr && (kind == ACC_CFG);
  assign eoi_wr    = reg_wr && (kind == ACC_EOI);
  assign eoi_id    = reg_wdata[EOI_ID_W-1:0];
  assign eoi_local = eoi_id < EOI_ID_W'(N_LOCAL);
  assign eoi_sh    = !eoi_local && (eoi_id < EOI_ID_W'(N_IDS));
  assign swi_vec   = N_SWI'(1) << reg_wdata[3:0];
  assign wdata_unused = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)                         glob_en <= 1'b0;
    else if (reg_wr && kind == ACC_CTRL) glob_en <= reg_wdata[0];
  end

  // ---------------- shared bank ----------------
  logic [NUM_SHARED-1:0]           sh_pend, sh_act, sh_en;
  logic [NUM_SHARED*PRIO_W-1:0]    sh_prio;
  logic [NUM_SHARED*NUM_CORES-1:0] sh_tgt;
  logic                            sh_ack;
  logic [SH_W-1:0]                 sh_ack_idx;

  // ---------------- per-core state ----------------
  logic [N_LOCAL-1:0]           loc_pend [NUM_CORES];
  logic [N_LOCAL-1:0]           loc_act  [NUM_CORES];
  logic [N_LOCAL-1:0]           loc_en   [NUM_CORES];
  logic [N_LOCAL*PRIO_W-1:0]    loc_prio [NUM_CORES];
  logic [N_LOCAL*NUM_CORES-1:0] loc_tgt  [NUM_CORES];
  logic [NUM_SHARED-1:0]        sh_route [NUM_CORES];
  logic [IDX_W-1:0]             pick_idx [NUM_CORES];
  logic [NUM_CORES-1:0]         found;
  logic [NUM_CORES-1:0]         loc_ack;
  logic                         ack_rd;
  logic                         ack_hit;
  logic                         sel_found;
  logic [IDX_W-1:0]             sel_idx;

  mc_irq_bank #(
    .N(NUM_SHARED), .PRIO_W(PRIO_W), .TGT_W(NUM_CORES)
  ) u_shared (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (spi_lines),
    .sw_set   ('0),
    .cfg_we   (wr_cfg && !cfg_local),
    .cfg_idx  (SH_W'(cfg_id - IDX_W'(N_LOCAL))),
    .cfg_en   (reg_wdata[CF_EN]),
    .cfg_prio (reg_wdata[CF_PRIO +: PRIO_W]),
    .cfg_tgt  (reg_wdata[CF_TGT +: NUM_CORES]),
    .ack_take (sh_ack),
    .ack_idx  (sh_ack_idx),
    .eoi_take (eoi_wr && eoi_sh),
    .eoi_idx  (SH_W'(eoi_id - EOI_ID_W'(N_LOCAL))),
    .pend_o   (sh_pend),
    .act_o    (sh_act),
    .en_o     (sh_en),
    .prio_o   (sh_prio),
    .tgt_o    (sh_tgt)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic             here;
    logic [N_IDS-1:0] elig;

    assign here = (reg_core == CORE_W'(c));

    mc_irq_bank #(
      .N(N_LOCAL), .PRIO_W(PRIO_W), .TGT_W(NUM_CORES)
    ) u_local (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  ({ppi_lines[16*c +: N_PRIV], {N_SWI{1'b0}}}),
      .sw_set   ({{N_PRIV{1'b0}},
                  (reg_wr && kind == ACC_SWI && reg_wdata[16+c]) ? swi_vec : {N_SWI{1'b0}}}),
      .cfg_we   (wr_cfg && cfg_local && here),
      .cfg_idx  (cfg_id[LW-1:0]),
      .cfg_en   (reg_wdata[CF_EN]),
      .cfg_prio (reg_wdata[CF_PRIO +: PRIO_W]),
      .cfg_tgt  ('0),
      .ack_take (loc_ack[c]),
      .ack_idx  (sel_idx[LW-1:0]),
      .eoi_take (eoi_wr && eoi_local && here),
      .eoi_idx  (eoi_id[LW-1:0]),
      .pend_o   (loc_pend[c]),
      .act_o    (loc_act[c]),
      .en_o     (loc_en[c]),
      .prio_o   (loc_prio[c]),
      .tgt_o    (loc_tgt[c])
    );

    for (genvar i = 0; i < NUM_SHARED; i++) begin : g_route
      assign sh_route[c][i] = sh_tgt[i*NUM_CORES + c];
    end

    assign elig = glob_en
      ? {sh_pend & ~sh_act & sh_en & sh_route[c],
         loc_pend[c] & ~loc_act[c] & loc_en[c]}
      : '0;

    mc_irq_pick #(.N(N_IDS), .PRIO_W(PRIO_W)) u_pick (
      .elig  (elig),
      .prio  ({sh_prio, loc_prio[c]}),
      .found (found[c]),
      .idx   (pick_idx[c])
    );

    assign loc_ack[c] = ack_hit && here && (sel_idx < IDX_W'(N_LOCAL));
  end

  assign irq = found;

  // ---------------- acknowledge ----------------
  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (reg_core == CORE_W'(c)) begin
        sel_found = found[c];
        sel_idx   = pick_idx[c];
      end
    end
  end

  assign ack_rd     = reg_rd && (kind == ACC_ACK);
  assign ack_hit    = ack_rd && sel_found;
  assign sh_ack     = ack_hit && (sel_idx >= IDX_W'(N_LOCAL));
  assign sh_ack_idx = SH_W'(sel_idx - IDX_W'(N_LOCAL));

  // ---------------- read data ----------------
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (kind)
        ACC_CTRL: reg_rdata[0] = glob_en;
        ACC_ACK:  reg_rdata = ack_hit ? {{(32-IDX_W){1'b0}}, sel_idx}
                                      : {{(32-EOI_ID_W){1'b0}}, SPURIOUS_ID};
        ACC_CFG: begin
          if (cfg_local) begin
            for (int c = 0; c < NUM_CORES; c++) begin
              if (reg_core == CORE_W'(c)) begin
                reg_rdata[CF_EN]                = loc_en[c][cfg_id[LW-1:0]];
                reg_rdata[CF_PRIO +: PRIO_W]    = loc_prio[c][cfg_id[LW-1:0]*PRIO_W +: PRIO_W];
                reg_rdata[CF_TGT +: NUM_CORES]  = loc_tgt[c][cfg_id[LW-1:0]*NUM_CORES +: NUM_CORES];
                reg_rdata[CF_PEND]              = loc_pend[c][cfg_id[LW-1:0]];
                reg_rdata[CF_ACT]               = loc_act[c][cfg_id[LW-1:0]];
              end
            end
          end else begin
            reg_rdata[CF_EN]               = sh_en[SH_W'(cfg_id - IDX_W'(N_LOCAL))];
            reg_rdata[CF_PRIO +: PRIO_W]   = sh_prio[SH_W'(cfg_id - IDX_W'(N_LOCAL))*PRIO_W +: PRIO_W];
            reg_rdata[CF_TGT +: NUM_CORES] = sh_tgt[SH_W'(cfg_id - IDX_W'(N_LOCAL))*NUM_CORES +: NUM_CORES];
            reg_rdata[CF_PEND]             = sh_pend[SH_W'(cfg_id - IDX_W'(N_LOCAL))];
            reg_rdata[CF_ACT]              = sh_act[SH_W'(cfg_id - IDX_W'(N_LOCAL))];
          end
        end
        default: reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mc_irq_dist_chk.sv
module mc_irq_dist_chk
  import mc_irq_pkg::*;
#(
  parameter int NUM_CORES  = 2,
  parameter int NUM_SHARED = 32,
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SH_W      = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1,
  localparam int N_IDS     = N_LOCAL + NUM_SHARED
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CORE_W-1:0]     reg_core,
  input logic                  reg_rd,
  input logic                  reg_wr,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [EOI_ID_W-1:0]   eoi_word,
  input logic [31:0]           reg_rdata,
  input logic [NUM_CORES-1:0]  irq,
  input logic                  glob_en,
  input logic [NUM_CORES-1:0]  loc_ack,
  input logic                  sh_ack,
  input logic [SH_W-1:0]       sh_ack_idx,
  input logic [NUM_SHARED-1:0] sh_act
);

  logic            irq_sel;
  logic            ack_rd;
  logic            eoi_sh_wr;
  logic [SH_W-1:0] eoi_sh_idx;

  assign irq_sel    = irq[reg_core];
  assign ack_rd     = reg_rd && (reg_addr == ADR_ACK);
  assign eoi_sh_wr  = reg_wr && !reg_rd && (reg_addr == ADR_EOI) &&
                      (eoi_word >= EOI_ID_W'(N_LOCAL)) && (eoi_word < EOI_ID_W'(N_IDS));
  assign eoi_sh_idx = SH_W'(eoi_word - EOI_ID_W'(N_LOCAL));

  // R2: no request leaves the block while the global enable is off
  p_irq_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> (irq == '0));

  // R6: acknowledging with the line low yields the spurious ID
  p_spurious_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq_sel) |-> (reg_rdata == 32'(SPURIOUS_ID)));

  // R4: acknowledging with the line high yields a real ID
  p_ack_id_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq_sel) |-> (reg_rdata < 32'(N_IDS)));

  // R10: an acknowledge touches at most one bank
  p_one_bank_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sh_ack, loc_ack}));

  // R11: an acknowledged shared interrupt is active next cycle
  p_shared_ack_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sh_ack |=> sh_act[$past(sh_ack_idx)]);

  // R7: retiring a shared ID clears its active state
  p_shared_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_sh_wr |=> !sh_act[$past(eoi_sh_idx)]);

endmodule

bind mc_irq_dist mc_irq_dist_chk #(
  .NUM_CORES(NUM_CORES), .NUM_SHARED(NUM_SHARED)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_core   (reg_core),
  .reg_rd     (reg_rd),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .eoi_word   (reg_wdata[9:0]),
  .reg_rdata  (reg_rdata),
  .irq        (irq),
  .glob_en    (glob_en),
  .loc_ack    (loc_ack),
  .sh_ack     (sh_ack),
  .sh_ack_idx (sh_ack_idx),
  .sh_act     (sh_act)
);

// File: tb/mc_irq_dist_tb_top.sv
`timescale 1ns/1ps
module mc_irq_dist_tb_top;

  localparam int NC = 2;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [16*NC-1:0] ppi_lines = '0;
  logic [NS-1:0] spi_lines = '0;
  logic [0:0]    reg_core = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [8:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;   // 125 MHz

  mc_irq_dist #(.NUM_CORES(NC), .NUM_SHARED(NS), .PRIO_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ppi_lines(ppi_lines), .spi_lines(spi_lines),
    .reg_core(reg_core), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam int A_CTRL = 'h000, A_SWI = 'h001, A_ACK = 'h002, A_EOI = 'h003, A_CFG = 'h100;

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int core, input int addr, input logic [31:0] d);
    @(negedge clk);
    reg_core = core[0:0]; reg_addr = addr[8:0]; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int core, input int addr, output logic [31:0] d);
    @(negedge clk);
    reg_core = core[0:0]; reg_addr = addr[8:0]; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic cfg(input int core, input int id, input int en, input int prio, input int tgt);
    wr(core, A_CFG + id, (tgt << 16) | (prio << 8) | en);
  endtask

  task automatic ack_expect(input string req, input int core, input int exp);
    logic [31:0] d;
    rd(core, A_ACK, d);
    check(req, d, exp);
  endtask

  task automatic cfg_expect(input string req, input int core, input int id, input logic [31:0] exp);
    logic [31:0] d;
    rd(core, A_CFG + id, d);
    check(req, d, exp);
  endtask

  task automatic irq_expect(input string req, input logic [NC-1:0] exp);
    @(negedge clk); #1;
    check(req, irq, exp);
  endtask

  task automatic pulse_spi(input int id);
    @(negedge clk); spi_lines[id-32] = 1'b1;
    @(negedge clk); spi_lines[id-32] = 1'b0;
  endtask

  task automatic pulse_ppi(input int core, input int id);
    @(negedge clk); ppi_lines[16*core + id - 16] = 1'b1;
    @(negedge clk); ppi_lines[16*core + id - 16] = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [31:0] d;
    irq_expect("R1 irq after reset", 2'b00);
    ack_expect("R1 ack after reset", 0, 1023);
    cfg_expect("R1 cfg word after reset", 0, 40, 32'h0);
    rd(0, A_CTRL, d);
    check("R1 ctrl after reset", d, 0);
  endtask

  task automatic t_regmap;
    cfg(0, 40, 1, 5, 1);
    cfg_expect("R12 shared cfg fields", 0, 40, 32'h0001_0501);
    wr(1, A_CFG + 20, 32'h0003_0703);
    cfg_expect("R12 local target reads zero", 1, 20, 32'h0000_0701);
    cfg(1, 20, 0, 0, 0);
  endtask

  task automatic t_gate;
    pulse_spi(40);
    irq_expect("R2 global off blocks irq", 2'b00);
    cfg_expect("R3 pulse held pending", 0, 40, 32'h4001_0501);
    wr(0, A_CTRL, 1);
    irq_expect("R11 routed to core0 only", 2'b01);
    cfg(0, 40, 0, 5, 1);
    irq_expect("R2 local enable off blocks irq", 2'b00);
    cfg(0, 40, 1, 5, 1);
    irq_expect("R2 re-enable restores irq", 2'b01);
    ack_expect("R4 ack returns id 40", 0, 40);
    irq_expect("R4 irq drops after ack", 2'b00);
    cfg_expect("R4 active and not pending", 0, 40, 32'h8001_0501);
    wr(0, A_EOI, 40);
    cfg_expect("R7 eoi clears active", 0, 40, 32'h0001_0501);
  endtask

  task automatic t_prio;
    cfg(0, 33, 1, 3, 1);
    cfg(0, 45, 1, 1, 1);
    cfg(0, 50, 1, 1, 1);
    pulse_spi(50); pulse_spi(33); pulse_spi(45);
    ack_expect("R4 lowest value first", 0, 45);
    ack_expect("R5 tie goes to lower id", 0, 50);
    ack_expect("R4 remaining id", 0, 33);
    ack_expect("R6 nothing left", 0, 1023);
    wr(0, A_EOI, 45); wr(0, A_EOI, 50); wr(0, A_EOI, 33);
  endtask

  task automatic t_spurious;
    cfg(0, 60, 0, 0, 1);
    pulse_spi(60);
    ack_expect("R6 disabled pending gives spurious", 0, 1023);
    cfg_expect("R6 spurious keeps pending", 0, 60, 32'h4001_0000);
    cfg(0, 60, 1, 0, 1);
    ack_expect("R6 pending survives for later ack", 0, 60);
    wr(0, A_EOI, 60);
  endtask

  task automatic t_active_mask;
    pulse_spi(40);
    ack_expect("R8 first ack", 0, 40);
    pulse_spi(40);
    irq_expect("R8 active hides new edge", 2'b00);
    cfg_expect("R8 pending while active", 0, 40, 32'hC001_0501);
    wr(0, A_EOI, 40);
    irq_expect("R8 irq after retire", 2'b01);
    ack_expect("R8 second delivery", 0, 40);
    wr(0, A_EOI, 40);
  endtask

  task automatic t_level;
    @(negedge clk); spi_lines[8] = 1'b1;
    repeat (3) @(negedge clk);
    ack_expect("R3 level line acked", 0, 40);
    repeat (5) @(negedge clk);
    irq_expect("R3 held level no retrigger", 2'b00);
    cfg_expect("R3 held level not pending", 0, 40, 32'h8001_0501);
    @(negedge clk); spi_lines[8] = 1'b0;
    wr(0, A_EOI, 40);
  endtask

  task automatic t_swi;
    cfg(0, 3, 1, 2, 0);
    cfg(1, 3, 1, 2, 0);
    wr(0, A_SWI, 32'h0002_0003);
    irq_expect("R9 only core1 targeted", 2'b10);
    ack_expect("R9 core1 gets id 3", 1, 3);
    wr(1, A_EOI, 3);
    wr(1, A_SWI, 32'h0003_0003);
    irq_expect("R9 both cores targeted", 2'b11);
    ack_expect("R9 core0 gets id 3", 0, 3);
    ack_expect("R9 core1 gets id 3 again", 1, 3);
    wr(0, A_EOI, 3); wr(1, A_EOI, 3);
    irq_expect("R9 all retired", 2'b00);
  endtask

  task automatic t_ppi;
    cfg(0, 20, 1, 4, 0);
    cfg(1, 20, 1, 4, 0);
    pulse_ppi(0, 20);
    irq_expect("R10 private line reaches own core", 2'b01);
    cfg_expect("R10 other copy untouched", 1, 20, 32'h0000_0401);
    ack_expect("R10 core0 gets id 20", 0, 20);
    wr(0, A_EOI, 20);
  endtask

  task automatic t_shared;
    cfg(0, 35, 1, 6, 3);
    pulse_spi(35);
    irq_expect("R11 shared to both cores", 2'b11);
    ack_expect("R11 core1 takes it", 1, 35);
    irq_expect("R11 gone from both", 2'b00);
    ack_expect("R11 core0 sees nothing", 0, 1023);
    wr(1, A_EOI, 35);
    cfg_expect("R11 retired by core1", 0, 35, 32'h0003_0601);
  endtask

  task automatic t_eoi_bad;
    pulse_spi(40);
    ack_expect("R7 setup ack", 0, 40);
    wr(0, A_EOI, 900);
    cfg_expect("R7 out-of-range eoi ignored", 0, 40, 32'h8001_0501);
    wr(0, A_EOI, 41);
    cfg_expect("R7 foreign eoi ignored", 0, 40, 32'h8001_0501);
    wr(0, A_EOI, 40);
    cfg_expect("R7 matching eoi retires", 0, 40, 32'h0001_0501);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_gate();
    t_prio();
    t_spurious();
    t_active_mask();
    t_level();
    t_swi();
    t_ppi();
    t_shared();
    t_eoi_bad();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule